// File: doc/BRIEF.md
# ROM Bank Select Register

This block sits on an 8-bit processor bus and chooses which quarter of 32 KB of ROM appears in the 8 KB read window at 0x2000–0x3FFF. Two 16 KB ROM devices share that window. A write to the decoded I/O address 0x1740 loads two data bits into a small bank register. The upper bit chooses the device. The lower bit drives ROM address line 13, which chooses the lower or upper 8 KB half of that device. Software writes the bank value first and then reads through the window.

Decoding takes two levels and is only partial. A first-level 2-to-4 decoder looks at address bits 10:9 and qualifies a second-level 3-to-8 decoder. That second decoder is active only during write cycles and looks at address bits 8:6. Its output 5 is the load strobe. No other address bits take part, so each alias that shares those five bit values also loads the register. The strobe acts as a synchronous write enable in the system clock domain.

The register is a four-state machine with the states BK_DEV0_LO, BK_DEV0_HI, BK_DEV1_LO and BK_DEV1_HI. The strobe makes the transition from any state to the state coded by data bits 1:0. Without a strobe each state holds itself. Power-on reset sends the machine to BK_DEV0_LO at once, without waiting for a clock. A watchdog reset does the same, unless the watchdog-disable input is high.

Top module: `rom_bank_sel`

## Requirements
- R1: After power-on reset the state is BK_DEV0_LO. A read in the window enables device 0 (`rom_q_ce_n`=0, `rom_np_ce_n`=1), with `rom_a13`=0 and `page1_n`=1.
- R2: A write to 0x1740 with data bits 1:0 = 00, 01, 10 or 11 selects, in that order, device 0 lower half, device 0 upper half, device 1 lower half and device 1 upper half. The new selection is visible right after the clock edge that samples the write.
- R3: Data bits 7:2 have no effect. A write of 0xFE selects device 1 lower half, and a write of 0x01 selects device 0 upper half.
- R4: A write does not load unless address bits 10 and 9 are both 1.
- R5: A write does not load unless address bits 8:6 equal 101.
- R6: A bus cycle with `cpu_wr`=0 at 0x1740 does not load, even if `cpu_rd`=1.
- R7: Address bits outside 10:6 are not decoded. Writes to the aliases 0x0740 and 0xF77F load the register.
- R8: Neither enable is low unless `cpu_rd`=1 and the address is inside 0x2000–0x3FFF, including both edges of the window. The two enables are never low together.
- R9: `page1_n` is always the inverse of the device-select bit. `rom_a13` always equals the half-select bit.
- R10: When `wd_rst_n`=0 and `wd_dis`=0, the register clears to BK_DEV0_LO at once, without waiting for a clock edge.
- R11: When `wd_dis`=1, `wd_rst_n`=0 has no effect on the register.
- R12: Between loads the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wr | input | 1 | Write cycle qualifier, active high |
| cpu_rd | input | 1 | Read cycle qualifier, active high |
| cpu_data | input | 8 | CPU write data |
| wd_rst_n | input | 1 | Watchdog reset, active low, asynchronous |
| wd_dis | input | 1 | Suppresses the watchdog reset when high |
| rom_q_ce_n | output | 1 | Chip enable of ROM device 0, active low |
| rom_np_ce_n | output | 1 | Chip enable of ROM device 1, active low |
| rom_a13 | output | 1 | Banked ROM address line 13 |
| page1_n | output | 1 | Inverse of the device-select bit |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data bus, level-1 select code 3 on bits 10:9, level-2 select code 5 on bits 8:6, and the window tag at bit 13. With these values, aliases whose undecoded bits are all zeros or all ones can be reached. Near-miss addresses that break exactly one decode level can also be reached. The window edges 0x1FFF, 0x2000, 0x3FFF and 0x4000 are exercised directly. The watchdog clear is checked one nanosecond after it asserts, mid-cycle, so that an implementation that waits for a clock edge is exposed.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
    typedef enum logic [1:0] {
        BK_DEV0_LO = 2'b00,
        BK_DEV0_HI = 2'b01,
        BK_DEV1_LO = 2'b10,
        BK_DEV1_HI = 2'b11
    } bank_e;
endpackage

// File: rtl/rbk_addr_decode.sv
module rbk_addr_decode #(
    parameter int ADDR_W = 16,
    parameter int L1_LO  = 9,
    parameter int L1_SEL = 3,
    parameter int L2_LO  = 6,
    parameter int L2_SEL = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              strobe
);
    localparam int L1_W = 2;
    localparam int L2_W = 3;
    localparam int L1_N = 1 << L1_W;
    localparam int L2_N = 1 << L2_W;

    logic [L1_W-1:0] l1_code;
    logic [L2_W-1:0] l2_code;
    logic [L1_N-1:0] l1_y_n;
    logic [L2_N-1:0] l2_y_n;
    logic            l2_en;
    logic            unused_addr;

    assign l1_code = addr[L1_LO+L1_W-1:L1_LO];
    assign l2_code = addr[L2_LO+L2_W-1:L2_LO];
    assign unused_addr = ^addr;

    // first level: 2-to-4, active-low outputs
    for (genvar gi = 0; gi < L1_N; gi++) begin : g_l1
        assign l1_y_n[gi] = ~(l1_code == L1_W'(gi));
    end

    // second level enabled by the chosen first-level output and a write
    assign l2_en = ~l1_y_n[L1_SEL] & wr;

    for (genvar gj = 0; gj < L2_N; gj++) begin : g_l2
        assign l2_y_n[gj] = ~(l2_en && (l2_code == L2_W'(gj)));
    end

    assign strobe = ~l2_y_n[L2_SEL];

    p_lvl1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (addr[L1_LO+1:L1_LO] == L1_W'(L1_SEL)));
    p_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (addr[L2_LO+2:L2_LO] == L2_W'(L2_SEL)));
    p_wronly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> wr);
    p_l2_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~l2_y_n));
endmodule

// File: rtl/rbk_bank_fsm.sv
module rbk_bank_fsm
    import rbk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_rst_n,
    input  logic       wd_dis,
    input  logic       strobe,
    input  logic [1:0] wdata,
    output logic       page0,
    output logic       page1,
    output logic       page1_n
);
    bank_e state;
    bank_e nxt;
    logic  clr_n;

    assign clr_n = rst_n & (wd_rst_n | wd_dis);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state <= BK_DEV0_LO;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (strobe) begin
            unique case (wdata)
                2'b00: nxt = BK_DEV0_LO;
                2'b01: nxt = BK_DEV0_HI;
                2'b10: nxt = BK_DEV1_LO;
                2'b11: nxt = BK_DEV1_HI;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            BK_DEV0_LO: begin page1 = 1'b0; page0 = 1'b0; end
            BK_DEV0_HI: begin page1 = 1'b0; page0 = 1'b1; end
            BK_DEV1_LO: begin page1 = 1'b1; page0 = 1'b0; end
            BK_DEV1_HI: begin page1 = 1'b1; page0 = 1'b1; end
        endcase
        page1_n = ~page1;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        strobe |=> (state == bank_e'($past(wdata))));
    p_hold_r12: assert property (@(posedge clk) disable iff (!clr_n)
        !strobe |=> $stable(state));
    p_wd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_rst_n && !wd_dis) |-> (state == BK_DEV0_LO));
endmodule

// File: rtl/rbk_rom_window.sv
module rbk_rom_window #(
    parameter int ADDR_W  = 16,
    parameter int WIN_BIT = 13,
    parameter int WIN_TAG = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              page0,
    input  logic              page1,
    output logic [1:0]        ce_n,
    output logic              a13
);
    localparam int TAG_W = ADDR_W - WIN_BIT;

    logic hit;
    logic unused_addr_lo;

    assign unused_addr_lo = ^addr[WIN_BIT-1:0];
    assign hit = rd && (addr[ADDR_W-1:WIN_BIT] == TAG_W'(WIN_TAG));

    for (genvar gd = 0; gd < 2; gd++) begin : g_dev
        assign ce_n[gd] = ~(hit && (page1 == gd[0]));
    end

    assign a13 = page0;
endmodule

// File: rtl/rom_bank_sel.sv
module rom_bank_sel #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int L1_LO   = 9,
    parameter int L1_SEL  = 3,
    parameter int L2_LO   = 6,
    parameter int L2_SEL  = 5,
    parameter int WIN_BIT = 13,
    parameter int WIN_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              wd_rst_n,
    input  logic              wd_dis,
    output logic              rom_q_ce_n,
    output logic              rom_np_ce_n,
    output logic              rom_a13,
    output logic              page1_n
);
    logic       strobe;
    logic       page0;
    logic       page1;
    logic [1:0] ce_n;
    logic       unused_data_hi;

    assign unused_data_hi = ^cpu_data[DATA_W-1:2];

    rbk_addr_decode #(
        .ADDR_W(ADDR_W), .L1_LO(L1_LO), .L1_SEL(L1_SEL),
        .L2_LO(L2_LO), .L2_SEL(L2_SEL)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wr(cpu_wr), .strobe(strobe)
    );

    rbk_bank_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wd_rst_n(wd_rst_n), .wd_dis(wd_dis),
        .strobe(strobe), .wdata(cpu_data[1:0]),
        .page0(page0), .page1(page1), .page1_n(page1_n)
    );

    rbk_rom_window #(
        .ADDR_W(ADDR_W), .WIN_BIT(WIN_BIT), .WIN_TAG(WIN_TAG)
    ) u_win (
        .addr(cpu_addr), .rd(cpu_rd), .page0(page0), .page1(page1),
        .ce_n(ce_n), .a13(rom_a13)
    );

    assign rom_q_ce_n  = ce_n[0];
    assign rom_np_ce_n = ce_n[1];

    p_ce_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |-> (rom_q_ce_n && rom_np_ce_n));
    p_ce_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_q_ce_n && !rom_np_ce_n));
    p_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_np_ce_n |-> !page1_n);
endmodule

// File: tb/sim_rom_bank_sel.sv
module sim_rom_bank_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_data = '0;
    logic        wd_rst_n = 1'b1;
    logic        wd_dis = 1'b0;
    logic        rom_q_ce_n, rom_np_ce_n, rom_a13, page1_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rom_bank_sel u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_data(cpu_data), .wd_rst_n(wd_rst_n),
        .wd_dis(wd_dis), .rom_q_ce_n(rom_q_ce_n), .rom_np_ce_n(rom_np_ce_n),
        .rom_a13(rom_a13), .page1_n(page1_n)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // one bus write cycle, starting and ending at a falling edge
    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = '0; cpu_data = '0;
    endtask

    // read inside the window and compare {q_ce_n, np_ce_n, a13, page1_n}
    task automatic chk_map(input string tag, input logic dev1, input logic hi);
        cpu_rd = 1'b1; cpu_addr = 16'h2A55;
        #1;
        chk(tag, {4'h0, rom_q_ce_n, rom_np_ce_n, rom_a13, page1_n},
                 {4'h0, dev1, ~dev1, hi, ~dev1});
        cpu_rd = 1'b0; cpu_addr = '0;
    endtask

    task automatic t_reset();
        chk_map("R1 reset state", 1'b0, 1'b0);
    endtask

    task automatic t_values();
        for (int v = 3; v >= 0; v--) begin
            bus_wr(16'h1740, 8'(v));
            chk_map($sformatf("R2 value %0d", v), v[1], v[0]);
            repeat (3) @(negedge clk);
            chk_map($sformatf("R12 hold %0d", v), v[1], v[0]);
        end
    endtask

    task automatic t_high_bits();
        bus_wr(16'h1740, 8'hFE);
        chk_map("R3 data FE", 1'b1, 1'b0);
        bus_wr(16'h1740, 8'h01);
        chk_map("R3 data 01", 1'b0, 1'b1);
    endtask

    task automatic t_level1();
        bus_wr(16'h1740, 8'h03);
        bus_wr(16'h1540, 8'h00);
        chk_map("R4 A9 low", 1'b1, 1'b1);
        bus_wr(16'h1340, 8'h00);
        chk_map("R4 A10 low", 1'b1, 1'b1);
    endtask

    task automatic t_level2();
        bus_wr(16'h1740, 8'h03);
        bus_wr(16'h1700, 8'h00);
        chk_map("R5 sel 100", 1'b1, 1'b1);
        bus_wr(16'h17C0, 8'h00);
        chk_map("R5 sel 111", 1'b1, 1'b1);
        bus_wr(16'h1640, 8'h00);
        chk_map("R5 sel 001", 1'b1, 1'b1);
    endtask

    task automatic t_read_cycle();
        bus_wr(16'h1740, 8'h02);
        @(negedge clk);
        cpu_addr = 16'h1740; cpu_data = 8'h01; cpu_rd = 1'b1; cpu_wr = 1'b0;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = '0; cpu_data = '0;
        chk_map("R6 read at 1740", 1'b1, 1'b0);
    endtask

    task automatic t_alias();
        bus_wr(16'h0740, 8'h03);
        chk_map("R7 alias 0740", 1'b1, 1'b1);
        bus_wr(16'hF77F, 8'h01);
        chk_map("R7 alias F77F", 1'b0, 1'b1);
    endtask

    task automatic t_window();
        bus_wr(16'h1740, 8'h02);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 16'h1FFF; #1;
        chk("R8 below window", {6'h0, rom_q_ce_n, rom_np_ce_n}, 8'h03);
        cpu_addr = 16'h2000; #1;
        chk("R8 window low edge", {6'h0, rom_q_ce_n, rom_np_ce_n}, 8'h02);
        cpu_addr = 16'h3FFF; #1;
        chk("R8 window high edge", {6'h0, rom_q_ce_n, rom_np_ce_n}, 8'h02);
        cpu_addr = 16'h4000; #1;
        chk("R8 above window", {6'h0, rom_q_ce_n, rom_np_ce_n}, 8'h03);
        cpu_rd = 1'b0; cpu_addr = 16'h2500; #1;
        chk("R8 no read", {6'h0, rom_q_ce_n, rom_np_ce_n}, 8'h03);
        chk("R9 page1_n and a13", {6'h0, page1_n, rom_a13}, 8'h00);
        cpu_addr = '0;
    endtask

    task automatic t_watchdog();
        bus_wr(16'h1740, 8'h03);
        @(negedge clk);
        #2 wd_rst_n = 1'b0;
        #1;
        chk("R10 async clear", {6'h0, page1_n, rom_a13}, 8'h02);
        @(negedge clk);
        @(negedge clk);
        wd_rst_n = 1'b1;
        chk_map("R10 cleared", 1'b0, 1'b0);
    endtask

    task automatic t_wd_disable();
        bus_wr(16'h1740, 8'h03);
        @(negedge clk);
        wd_dis = 1'b1;
        #2 wd_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_map("R11 suppressed", 1'b1, 1'b1);
        wd_rst_n = 1'b1;
        @(negedge clk);
        wd_dis = 1'b0;
        chk_map("R11 after release", 1'b1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_values();
        t_high_bits();
        t_level1();
        t_level2();
        t_read_cycle();
        t_alias();
        t_window();
        t_watchdog();
        t_wd_disable();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule